// File: doc/BRIEF.md
# Indexed pixel pipeline with hardware cursor

This block turns a raster stream of 8-bit frame-memory bytes into 24-bit RGB pixels. Each clock it can accept one pixel: its column and row on the screen and the byte read for it from frame memory. The byte picks an entry in a 256-entry colour table. A 64x64 cursor image, two bits per pixel, is then laid over the picture. The result leaves with a valid strobe and an end-of-frame strobe. A forced-blank control turns every pixel black, and a separate control bit hides the cursor.

A register block outside this unit loads the colour table, the cursor pattern and the three cursor colours through plain write ports. It also supplies the screen size, the cursor origin, the control word and the top-of-screen byte offset. The block produces the frame-memory byte address of the next pixel to fetch. That address starts at the top-of-screen offset and moves forward by one for every accepted pixel. Both lookups are registered, so every result comes out a fixed two cycles after its input. Column, row and strobes are delayed to stay in line with it.

Top module: `idx_pixel_pipe`

## Requirements
- R1: A pixel accepted with `in_valid` high shows colour-table entry `in_data` on `out_rgb` two clock cycles later (red in bits 23:16, green 15:8, blue 7:0), unless the cursor or blanking overrides it. The entry is the one written through `pal_we`/`pal_waddr`/`pal_wdata` in the same bit layout.
- R2: `out_valid`, `out_x` and `out_y` repeat `in_valid`, `in_x` and `in_y` exactly two clock cycles later.
- R3: The cursor window is the set of pixels whose x lies in [cx, cx+64) and whose y lies in [cy, cy+64). Here cx is `cfg_curs_pos[23:12]` and cy is `cfg_curs_pos[11:0]`. Pixels outside the window never show a cursor colour.
- R4: Inside the window, with dx = x-cx and dy = y-cy, the cursor code is bits [2k+1:2k] of pattern word dy*8 + dx/8, where k = dx mod 8. Pattern words are written through `pat_we`/`pat_waddr`/`pat_wdata`.
- R5: A cursor code of 0 lets the colour-table colour through. Codes 1, 2 and 3 show cursor colours 0, 1 and 2. These colours are written through `cpal_we` at `cpal_waddr` 0, 1 and 2, in the same RGB layout as R1.
- R6: While `cfg_ctrl[23]` is 1 for a pixel, that pixel shows its colour-table colour even inside the cursor window.
- R7: While `cfg_ctrl[10]` is 1 for a pixel, its output colour is 0, whatever the cursor shows.
- R8: `out_eof` is 1 exactly with the output of an accepted pixel at x = `cfg_width`-1 and y = `cfg_height`-1, and is 0 otherwise.
- R9: `fb_addr` equals `cfg_top` plus the number of pixels accepted since reset or since the last end-of-frame pixel, modulo 2^24.
- R10: Synchronous active-low reset clears `out_valid`, `out_eof` and `out_rgb` to 0. It restarts the address count so that `fb_addr` equals `cfg_top`, and it sets all three cursor colours to black.
- R11: A cursor-colour write to `cpal_waddr` 3 has no effect: the three cursor colours keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_width | input | 12 | Visible pixels per line |
| cfg_height | input | 12 | Visible lines per frame |
| cfg_ctrl | input | 32 | Control word; bit 10 forces blank, bit 23 hides the cursor |
| cfg_curs_pos | input | 24 | Cursor origin: x in [23:12], y in [11:0] |
| cfg_top | input | 24 | Frame-memory byte offset of the first pixel |
| pal_we | input | 1 | Colour-table write enable |
| pal_waddr | input | 8 | Colour-table entry to write |
| pal_wdata | input | 24 | Colour-table RGB value |
| pat_we | input | 1 | Cursor-pattern write enable |
| pat_waddr | input | 9 | Cursor-pattern word to write |
| pat_wdata | input | 16 | Cursor-pattern word, eight 2-bit codes |
| cpal_we | input | 1 | Cursor-colour write enable |
| cpal_waddr | input | 2 | Cursor colour to write (0..2) |
| cpal_wdata | input | 24 | Cursor-colour RGB value |
| in_valid | input | 1 | A pixel is presented this cycle |
| in_x | input | 12 | Pixel column |
| in_y | input | 12 | Pixel row |
| in_data | input | 8 | Frame-memory byte for the pixel |
| fb_addr | output | 24 | Frame-memory byte address of the next pixel |
| out_valid | output | 1 | Output pixel valid |
| out_x | output | 12 | Output pixel column |
| out_y | output | 12 | Output pixel row |
| out_rgb | output | 24 | Output pixel colour |
| out_eof | output | 1 | Output pixel is the last of the frame |

## Verification
The bench places the cursor so that its window reaches past the right and bottom edges of a narrow screen, and also puts it at the origin. A window compare that is off by one, or that wraps, then colours a column or row that should be clear. The pattern words hold codes that differ from pixel to pixel, so a swapped word index or a wrong bit pair inside a word shows up as wrong cursor pixels. Frames are run with the cursor hidden, with blanking on, with gaps in the pixel stream, with an ignored write to cursor colour 3, and before any cursor colour has been written. A design that leaks the cursor through the hide bit, lets cursor colours through blanking, counts idle cycles in the address, or accepts the fourth colour write would show a wrong colour or address in the first affected cycle.

// File: rtl/ipp_pkg.sv
// Shared constants and types for the indexed pixel pipeline.
// Assumes a fixed 64x64 cursor with eight 2-bit codes per pattern word.
package ipp_pkg;
    localparam int CUR_LOG   = 6;                        // cursor edge is 2**CUR_LOG
    localparam int CUR_DIM   = 1 << CUR_LOG;
    localparam int SEL_W     = 3;                        // code slot within a word
    localparam int PIX_WORD  = 1 << SEL_W;
    localparam int CODE_W    = 2;
    localparam int WORD_W    = PIX_WORD * CODE_W;
    localparam int PAT_WORDS = CUR_DIM * CUR_DIM / PIX_WORD;
    localparam int PAT_AW    = $clog2(PAT_WORDS);
    localparam int RGB_W     = 24;
    localparam int BLANK_BIT = 10;
    localparam int NOCUR_BIT = 23;

    typedef logic [RGB_W-1:0] rgb_t;

    typedef enum logic [CODE_W-1:0] {
        CUR_CLEAR = 2'd0,
        CUR_COL0  = 2'd1,
        CUR_COL1  = 2'd2,
        CUR_COL2  = 2'd3
    } cur_code_e;
endpackage

// File: rtl/ipp_sync_ram.sv
// Simple dual-port storage: one write port, one registered read port.
// A read and a write to the same entry in one cycle return the old data.
// Contents are not cleared by reset; only the read register is.
module ipp_sync_ram #(
    parameter int W     = 24,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // store a word on write enable
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // registered read of the addressed word
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= mem[raddr];
    end
endmodule

// File: rtl/ipp_cursor_locate.sv
// Finds whether a pixel lies in the cursor window and where its code sits.
// Purely combinational; coordinates are unsigned, and a pixel left of or
// above the origin gives a negative difference, which counts as outside.
module ipp_cursor_locate
    import ipp_pkg::*;
#(
    parameter int COORD_W = 12
) (
    input  logic [COORD_W-1:0] px,
    input  logic [COORD_W-1:0] py,
    input  logic [COORD_W-1:0] org_x,
    input  logic [COORD_W-1:0] org_y,
    output logic               hit,
    output logic [PAT_AW-1:0]  word_idx,
    output logic [SEL_W-1:0]   slot
);
    logic [COORD_W:0] dx, dy;
    logic             in_x, in_y;

    // offsets from the origin with a sign bit, then the window tests
    always_comb begin
        dx       = {1'b0, px} - {1'b0, org_x};
        dy       = {1'b0, py} - {1'b0, org_y};
        in_x     = !dx[COORD_W] && (dx[COORD_W-1:CUR_LOG] == '0);
        in_y     = !dy[COORD_W] && (dy[COORD_W-1:CUR_LOG] == '0);
        hit      = in_x && in_y;
        word_idx = {dy[CUR_LOG-1:0], dx[CUR_LOG-1:SEL_W]};
        slot     = dx[SEL_W-1:0];
    end
endmodule

// File: rtl/ipp_addr_gen.sv
// Frame-memory address generator: counts accepted pixels from the frame
// start and adds the top-of-screen offset. The count returns to zero after
// the last pixel of a frame.
module ipp_addr_gen #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              wrap,
    input  logic [ADDR_W-1:0] top,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] offset;

    // pixel count within the current frame
    always_ff @(posedge clk) begin
        if (!rst_n)    offset <= '0;
        else if (step) offset <= wrap ? '0 : offset + 1'b1;
    end

    // address of the next byte to fetch
    assign addr = top + offset;
endmodule

// File: rtl/idx_pixel_pipe.sv
// Indexed pixel pipeline with cursor overlay.
// Stage 1 registers the colour-table and pattern lookups together with the
// pixel's position, window decision and control bits. Stage 2 picks the
// colour and registers the outputs. Latency is two cycles for every field.
// Assumes configuration and stored contents are not changed while pixels
// are in flight.
module idx_pixel_pipe
    import ipp_pkg::*;
#(
    parameter int COORD_W   = 12,
    parameter int ADDR_W    = 24,
    parameter int PAL_DEPTH = 256,
    localparam int IDX_W    = $clog2(PAL_DEPTH),
    localparam int POS_W    = 2 * COORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] cfg_width,
    input  logic [COORD_W-1:0] cfg_height,
    input  logic [31:0]        cfg_ctrl,
    input  logic [POS_W-1:0]   cfg_curs_pos,
    input  logic [ADDR_W-1:0]  cfg_top,
    input  logic               pal_we,
    input  logic [IDX_W-1:0]   pal_waddr,
    input  logic [RGB_W-1:0]   pal_wdata,
    input  logic               pat_we,
    input  logic [PAT_AW-1:0]  pat_waddr,
    input  logic [WORD_W-1:0]  pat_wdata,
    input  logic               cpal_we,
    input  logic [1:0]         cpal_waddr,
    input  logic [RGB_W-1:0]   cpal_wdata,
    input  logic               in_valid,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    input  logic [IDX_W-1:0]   in_data,
    output logic [ADDR_W-1:0]  fb_addr,
    output logic               out_valid,
    output logic [COORD_W-1:0] out_x,
    output logic [COORD_W-1:0] out_y,
    output logic [RGB_W-1:0]   out_rgb,
    output logic               out_eof
);
    localparam int NCUR = 3;

    logic                  unused_ctrl;
    logic                  last_pix;
    logic                  hit;
    logic [PAT_AW-1:0]     word_idx;
    logic [SEL_W-1:0]      slot;
    rgb_t                  pal_q;
    logic [WORD_W-1:0]     pat_q;
    rgb_t                  cur_col [NCUR];
    rgb_t                  pick;
    cur_code_e             code;

    logic                  s1_valid, s1_eof, s1_hit, s1_blank, s1_nocur;
    logic [COORD_W-1:0]    s1_x, s1_y;
    logic [SEL_W-1:0]      s1_slot;

    assign unused_ctrl = ^{cfg_ctrl[31:NOCUR_BIT+1], cfg_ctrl[NOCUR_BIT-1:BLANK_BIT+1],
                           cfg_ctrl[BLANK_BIT-1:0]};

    // last pixel of the frame
    assign last_pix = (in_x == cfg_width - COORD_W'(1)) && (in_y == cfg_height - COORD_W'(1));

    ipp_cursor_locate #(.COORD_W(COORD_W)) u_locate (
        .px       (in_x),
        .py       (in_y),
        .org_x    (cfg_curs_pos[POS_W-1:COORD_W]),
        .org_y    (cfg_curs_pos[COORD_W-1:0]),
        .hit      (hit),
        .word_idx (word_idx),
        .slot     (slot)
    );

    ipp_sync_ram #(.W(RGB_W), .DEPTH(PAL_DEPTH)) u_palette (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pal_we),
        .waddr (pal_waddr),
        .wdata (pal_wdata),
        .raddr (in_data),
        .rdata (pal_q)
    );

    ipp_sync_ram #(.W(WORD_W), .DEPTH(PAT_WORDS)) u_pattern (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pat_we),
        .waddr (pat_waddr),
        .wdata (pat_wdata),
        .raddr (word_idx),
        .rdata (pat_q)
    );

    ipp_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (in_valid),
        .wrap  (last_pix),
        .top   (cfg_top),
        .addr  (fb_addr)
    );

    // cursor colour registers, one per non-clear code
    for (genvar gi = 0; gi < NCUR; gi++) begin : g_cur_col
        always_ff @(posedge clk) begin
            if (!rst_n)                                       cur_col[gi] <= '0;
            else if (cpal_we && cpal_waddr == 2'(gi))         cur_col[gi] <= cpal_wdata;
        end
    end

    // stage 1: align position, strobes and decisions with the lookups
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_eof   <= 1'b0;
            s1_hit   <= 1'b0;
            s1_blank <= 1'b0;
            s1_nocur <= 1'b0;
            s1_x     <= '0;
            s1_y     <= '0;
            s1_slot  <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_eof   <= in_valid && last_pix;
            s1_hit   <= hit;
            s1_blank <= cfg_ctrl[BLANK_BIT];
            s1_nocur <= cfg_ctrl[NOCUR_BIT];
            s1_x     <= in_x;
            s1_y     <= in_y;
            s1_slot  <= slot;
        end
    end

    // stage 2 selection: blank, then cursor colour, then table colour
    always_comb begin
        code = cur_code_e'(pat_q[{s1_slot, 1'b0} +: CODE_W]);
        pick = pal_q;
        if (s1_hit && !s1_nocur) begin
            case (code)
                CUR_COL0: pick = cur_col[0];
                CUR_COL1: pick = cur_col[1];
                CUR_COL2: pick = cur_col[2];
                default:  pick = pal_q;
            endcase
        end
        if (s1_blank) pick = '0;
    end

    // stage 2: output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_eof   <= 1'b0;
            out_rgb   <= '0;
            out_x     <= '0;
            out_y     <= '0;
        end else begin
            out_valid <= s1_valid;
            out_eof   <= s1_eof;
            out_rgb   <= pick;
            out_x     <= s1_x;
            out_y     <= s1_y;
        end
    end
endmodule

// File: rtl/ipp_chk.sv
// Property checker for the indexed pixel pipeline, bound to the top.
// Tracks cycles since reset so that two-cycle look-backs never reach into
// reset or time zero.
module ipp_chk #(
    parameter int COORD_W = 12,
    parameter int ADDR_W  = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic [COORD_W-1:0] cfg_width,
    input logic [COORD_W-1:0] cfg_height,
    input logic [31:0]        cfg_ctrl,
    input logic [ADDR_W-1:0]  cfg_top,
    input logic               in_valid,
    input logic [COORD_W-1:0] in_x,
    input logic [COORD_W-1:0] in_y,
    input logic [ADDR_W-1:0]  fb_addr,
    input logic               out_valid,
    input logic [COORD_W-1:0] out_x,
    input logic [COORD_W-1:0] out_y,
    input logic [23:0]        out_rgb,
    input logic               out_eof
);
    logic [1:0]        age;
    logic              at_end;
    logic [ADDR_W-1:0] rel;
    logic              unused_ctrl;

    assign unused_ctrl = ^{cfg_ctrl[31:11], cfg_ctrl[9:0]};
    assign at_end = (in_x == cfg_width - COORD_W'(1)) && (in_y == cfg_height - COORD_W'(1));
    assign rel    = fb_addr - cfg_top;

    // saturating count of clock edges out of reset
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R2
    valid_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R2
    coord_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && out_valid) |-> (out_x == $past(in_x, 2) && out_y == $past(in_y, 2)));

    // R7
    blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && out_valid && $past(cfg_ctrl[10], 2)) |-> (out_rgb == 24'd0));

    // R8
    eof_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (out_eof == $past(in_valid && at_end, 2)));

    // R8
    eof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_valid);

    // R9
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !at_end) |=> (rel == $past(rel) + 1'b1));

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (rel == $past(rel)));

    // R9
    addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && at_end) |=> (fb_addr == cfg_top));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_eof && out_rgb == 24'd0 && fb_addr == cfg_top));
endmodule

bind idx_pixel_pipe ipp_chk #(.COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_ipp_chk (.*);

// File: tb/test_idx_pixel_pipe.sv
// Bench for idx_pixel_pipe: a behavioural model predicts every output one
// edge after the design registers it and is compared on every clock.
module test_idx_pixel_pipe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cfg_width = 12'd80, cfg_height = 12'd70;
    logic [31:0] cfg_ctrl = '0;
    logic [23:0] cfg_curs_pos = '0;
    logic [23:0] cfg_top = 24'h000100;
    logic        pal_we = 0;  logic [7:0] pal_waddr = 0;  logic [23:0] pal_wdata = 0;
    logic        pat_we = 0;  logic [8:0] pat_waddr = 0;  logic [15:0] pat_wdata = 0;
    logic        cpal_we = 0; logic [1:0] cpal_waddr = 0; logic [23:0] cpal_wdata = 0;
    logic        in_valid = 0;
    logic [11:0] in_x = 0, in_y = 0;
    logic [7:0]  in_data = 0;
    logic [23:0] fb_addr;
    logic        out_valid, out_eof;
    logic [11:0] out_x, out_y;
    logic [23:0] out_rgb;

    int vectors = 0, miscompares = 0;

    idx_pixel_pipe i_idx_pixel_pipe (.*);

    always #4 clk = ~clk;   // 125 MHz

    // model state
    int   pal_m [256];
    int   pat_m [512];
    int   cp_m  [3];
    bit   cp_written = 0;
    int   off_m = 0;
    bit   e_valid = 0, e_eof = 0;
    int   e_x = 0, e_y = 0, e_rgb = 0;
    string e_tag = "R1";

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock model and comparison
    always @(posedge clk) begin
        bit    n_valid, n_eof, win, blank, nocur;
        int    n_x, n_y, n_rgb, dx, dy, code, xc, yc;
        string n_tag;
        if (!rst_n) begin
            e_valid = 0; e_eof = 0; e_rgb = 0; off_m = 0;
            for (int i = 0; i < 3; i++) cp_m[i] = 0;
            cp_written = 0;
        end else begin
            n_valid = in_valid; n_x = in_x; n_y = in_y;
            n_eof = in_valid && (in_x == cfg_width - 1) && (in_y == cfg_height - 1);
            xc = cfg_curs_pos[23:12]; yc = cfg_curs_pos[11:0];
            dx = n_x - xc; dy = n_y - yc;
            win = (dx >= 0 && dx < 64 && dy >= 0 && dy < 64);
            code = win ? ((pat_m[dy * 8 + dx / 8] >> ((dx % 8) * 2)) & 3) : 0;
            blank = cfg_ctrl[10]; nocur = cfg_ctrl[23];
            if (blank)                      begin n_rgb = 0; n_tag = "R7"; end
            else if (win && nocur)          begin n_rgb = pal_m[in_data]; n_tag = "R6"; end
            else if (win && code != 0) begin
                n_rgb = cp_m[code - 1];
                if (!cp_written)            n_tag = "R10";
                else if (code == 3)         n_tag = "R11";
                else                        n_tag = "R5";
            end
            else if (win && (dx == 0 || dx == 63 || dy == 0 || dy == 63)) begin
                n_rgb = pal_m[in_data]; n_tag = "R3";
            end
            else if (win)                   begin n_rgb = pal_m[in_data]; n_tag = "R4"; end
            else                            begin n_rgb = pal_m[in_data]; n_tag = "R1"; end
            if (in_valid) off_m = n_eof ? 0 : off_m + 1;
            if (pal_we) pal_m[pal_waddr] = pal_wdata;
            if (pat_we) pat_m[pat_waddr] = pat_wdata;
            if (cpal_we && cpal_waddr < 3) begin cp_m[cpal_waddr] = cpal_wdata; cp_written = 1; end
            #2;
            chk(out_valid == e_valid, "R2", out_valid, e_valid);
            if (e_valid) begin
                chk(out_x == e_x[11:0] && out_y == e_y[11:0], "R2", {out_x, out_y}, {e_x[11:0], e_y[11:0]});
                chk(out_eof == e_eof, "R8", out_eof, e_eof);
                chk(out_rgb == e_rgb[23:0], e_tag, out_rgb, e_rgb);
            end else begin
                chk(out_eof == 1'b0, "R8", out_eof, 0);
            end
            chk(fb_addr == 24'(cfg_top + off_m), "R9", fb_addr, 24'(cfg_top + off_m));
            e_valid = n_valid; e_eof = n_eof; e_x = n_x; e_y = n_y; e_rgb = n_rgb; e_tag = n_tag;
        end
    end

    task automatic run_frame(input int w, input int h, input int seed, input int gap);
        int n = 0;
        cfg_width = 12'(w); cfg_height = 12'(h);
        for (int y = 0; y < h; y++) begin
            for (int x = 0; x < w; x++) begin
                n++;
                if (gap != 0 && n % gap == 0) begin
                    @(negedge clk); in_valid = 0;
                end
                @(negedge clk);
                in_valid = 1; in_x = 12'(x); in_y = 12'(y);
                in_data = 8'(x * 5 + y * 11 + seed);
            end
        end
        @(negedge clk); in_valid = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic write_cursor_colour(input int a, input int v);
        @(negedge clk); cpal_we = 1; cpal_waddr = 2'(a); cpal_wdata = 24'(v);
        @(negedge clk); cpal_we = 0;
    endtask

    initial begin
        #(8 * 150000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state at the ports
        chk(out_valid == 0 && out_eof == 0, "R10", {out_valid, out_eof}, 0);
        chk(out_rgb == 0, "R10", out_rgb, 0);
        chk(fb_addr == cfg_top, "R10", fb_addr, cfg_top);
        for (int i = 0; i < 256; i++) begin
            @(negedge clk); pal_we = 1; pal_waddr = 8'(i);
            pal_wdata = {8'(i), 8'(i * 3), 8'(255 - i)};
        end
        @(negedge clk); pal_we = 0;
        for (int i = 0; i < 512; i++) begin
            @(negedge clk); pat_we = 1; pat_waddr = 9'(i);
            pat_wdata = 16'(i * 40503 + 12345);
        end
        @(negedge clk); pat_we = 0;
        // R10 cursor colours still black after reset
        cfg_curs_pos = {12'd10, 12'd5};
        run_frame(80, 70, 1, 0);
        write_cursor_colour(0, 24'hff0000);
        write_cursor_colour(1, 24'h00ff00);
        write_cursor_colour(2, 24'h0000ff);
        write_cursor_colour(3, 24'hffffff);   // R11 ignored address
        cfg_curs_pos = {12'd20, 12'd3};
        run_frame(80, 70, 2, 13);
        cfg_ctrl = 32'h0080_0000;             // R6 cursor hidden
        run_frame(80, 70, 3, 0);
        cfg_ctrl = 32'h0000_0400;             // R7 blank
        cfg_top = 24'hfffff0;                 // R9 wrap of the address sum
        run_frame(80, 70, 4, 7);
        cfg_ctrl = 32'h0;
        cfg_curs_pos = {12'd70, 12'd40};      // R3 window past the edges
        run_frame(80, 70, 5, 0);
        cfg_curs_pos = {12'd0, 12'd0};
        cfg_top = 24'h000000;
        run_frame(32, 20, 6, 5);
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule